// File: doc/BRIEF.md
# Indirect Glyph Row Memory

This block stores up to sixteen user-defined 5x7 dot-matrix glyphs for a character display. A host reaches it over a small asynchronous-style bus with an 8-bit data path, a 5-bit address, an active-low chip enable, and active-low write and read strobes. A separate target-select input chooses between two targets. The first is a slot pointer register. The second is the row storage of the glyph that the pointer currently names.

To define a glyph, the host writes the slot number into the pointer and then writes the seven rows one after another, which takes eight bus writes in all. Each row write carries five dot bits, and the row is picked by the three low address bits. Both targets can be read back over the same bus. A separate combinational port lets display scanning logic fetch any row of any slot without going through the pointer.

Top module: `glyph_ram_top`

## Requirements
- R1: While `rst_n` is low, and after its release, the slot pointer holds 0 until the host writes it. A pointer read then returns 0x00.
- R2: A write with `tgt_reg`=1 latches `wdata[3:0]` as the slot pointer and ignores `wdata[7:4]`. A pointer read returns the slot in bits 3:0 with bits 7:4 at zero.
- R3: A write with `tgt_reg`=0 and `addr[2:0]` in the range 000 (row 1) to 110 (row 7) stores `wdata[4:0]` as that row of the slot the pointer names. `wdata[7:5]` and `addr[4:3]` are ignored.
- R4: A row read with `tgt_reg`=0 returns the stored 5 dots in bits 4:0 and zero in bits 7:5. Bit 4 is the leftmost column and bit 0 the rightmost.
- R5: Row code 111 holds no data. Writes to it change nothing, and reads of it return 0x00 on `rdata` and on `scan_dots`.
- R6: A cycle with chip enable, write and read strobes all low is neither a write nor a read. Storage and pointer are unchanged, and `rdata` is 0x00.
- R7: With `cs_n` high, no strobe has any effect.
- R8: `scan_dots` shows, in the same cycle, the dots stored at (`scan_slot`, `scan_row`), with the same column order as R4. A row write is visible there from the clock edge that stores it.
- R9: Rows written after a pointer change land in the new slot, and rows of every other slot keep their contents.
- R10: `rdata` is 0x00 in every cycle that is not a read (`cs_n`=0, `rd_n`=0, `wr_n`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes are taken on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Active-low chip enable |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| tgt_reg | input | 1 | 1 selects the slot pointer, 0 selects row storage |
| addr | input | 5 | Bus address; bits 2:0 choose the row |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when not reading |
| scan_slot | input | 4 | Slot number for the scan port |
| scan_row | input | 3 | Row code for the scan port |
| scan_dots | output | 5 | Dots of the addressed scan row |

## Verification
First a directed pass fills every row of every slot with a value that depends on its slot and row. This separates correct indirection from writes that land in the wrong slot or row. Random traffic follows, mixing pointer writes, row writes with random upper data and address bits, row code 111, reads, reads and writes with both strobes low, and strobes with chip enable high. Checks read back over the bus and through the scan port. This tells masking of the ignored bits apart from storing them, and shows that undefined or deselected cycles do not disturb state. A final mid-run reset shows that the pointer clears while the glyph contents stay.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
  parameter int unsigned SLOTS  = 16;
  parameter int unsigned ROWS   = 7;
  parameter int unsigned COLS   = 5;
  parameter int unsigned DATA_W = 8;
  parameter int unsigned ADDR_W = 5;

  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam int unsigned ROW_W  = $clog2(ROWS + 1);

  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [ROW_W-1:0]  row_t;
  typedef logic [COLS-1:0]   dots_t;

  typedef struct packed {
    logic wr_ptr;
    logic wr_row;
    logic rd_ptr;
    logic rd_row;
  } bus_op_t;
endpackage

// File: rtl/glyph_bus_decode.sv
module glyph_bus_decode
  import glyph_pkg::*;
#(
  parameter int unsigned RW = ROW_W,
  parameter int unsigned NROWS = ROWS
) (
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          tgt_reg,
  input  logic [RW-1:0] row_code,
  output bus_op_t       op
);
  logic wr_any;
  logic rd_any;
  logic row_ok;

  always_comb begin
    wr_any    = !cs_n && !wr_n && rd_n;
    rd_any    = !cs_n && !rd_n && wr_n;
    row_ok    = (32'(row_code) < NROWS);
    op.wr_ptr = wr_any && tgt_reg;
    op.wr_row = wr_any && !tgt_reg && row_ok;
    op.rd_ptr = rd_any && tgt_reg;
    op.rd_row = rd_any && !tgt_reg;
  end
endmodule

// File: rtl/glyph_slot_reg.sv
module glyph_slot_reg
  import glyph_pkg::*;
#(
  parameter int unsigned SW = SLOT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [SW-1:0] load_val,
  output logic [SW-1:0] slot_q
);
  logic [SW-1:0] slot_d;

  always_comb begin
    slot_d = slot_q;
    if (load_en) slot_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end
endmodule

// File: rtl/glyph_store.sv
module glyph_store
  import glyph_pkg::*;
#(
  parameter int unsigned NSLOTS = SLOTS,
  parameter int unsigned NROWS  = ROWS,
  parameter int unsigned NCOLS  = COLS,
  parameter int unsigned SW     = SLOT_W,
  parameter int unsigned RW     = ROW_W
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [SW-1:0]    wr_slot,
  input  logic [RW-1:0]    wr_row,
  input  logic [NCOLS-1:0] wr_dots,
  input  logic [SW-1:0]    rd_slot_a,
  input  logic [RW-1:0]    rd_row_a,
  output logic [NCOLS-1:0] rd_dots_a,
  input  logic [SW-1:0]    rd_slot_b,
  input  logic [RW-1:0]    rd_row_b,
  output logic [NCOLS-1:0] rd_dots_b
);
  logic [NCOLS-1:0] cells [NSLOTS][NROWS];

  always_ff @(posedge clk) begin
    for (int s = 0; s < NSLOTS; s++) begin
      for (int r = 0; r < NROWS; r++) begin
        if (wr_en && (32'(wr_slot) == s) && (32'(wr_row) == r))
          cells[s][r] <= wr_dots;
      end
    end
  end

  function automatic logic [NCOLS-1:0] fetch(input logic [SW-1:0] s,
                                             input logic [RW-1:0] r);
    logic [NCOLS-1:0] v;
    v = '0;
    for (int i = 0; i < NSLOTS; i++)
      for (int j = 0; j < NROWS; j++)
        if ((32'(s) == i) && (32'(r) == j)) v = cells[i][j];
    return v;
  endfunction

  always_comb begin
    rd_dots_a = fetch(rd_slot_a, rd_row_a);
    rd_dots_b = fetch(rd_slot_b, rd_row_b);
  end
endmodule

// File: rtl/glyph_ram_top.sv
module glyph_ram_top
  import glyph_pkg::*;
#(
  parameter int unsigned NSLOTS = SLOTS,
  parameter int unsigned NROWS  = ROWS,
  parameter int unsigned NCOLS  = COLS,
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned AW     = ADDR_W,
  localparam int unsigned SW    = $clog2(NSLOTS),
  localparam int unsigned RW    = $clog2(NROWS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          tgt_reg,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [SW-1:0] scan_slot,
  input  logic [RW-1:0] scan_row,
  output logic [NCOLS-1:0] scan_dots
);
  logic             rst_meta;
  logic             rst_sync_n;
  bus_op_t          op;
  logic [SW-1:0]    slot_q;
  logic [NCOLS-1:0] bus_dots;
  logic             unused_hi;

  assign unused_hi = ^{addr[AW-1:RW], wdata[DW-1:NCOLS]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  glyph_bus_decode #(.RW(RW), .NROWS(NROWS)) u_decode (
    .cs_n     (cs_n),
    .wr_n     (wr_n),
    .rd_n     (rd_n),
    .tgt_reg  (tgt_reg),
    .row_code (addr[RW-1:0]),
    .op       (op)
  );

  glyph_slot_reg #(.SW(SW)) u_slot (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_en  (op.wr_ptr),
    .load_val (wdata[SW-1:0]),
    .slot_q   (slot_q)
  );

  glyph_store #(
    .NSLOTS(NSLOTS), .NROWS(NROWS), .NCOLS(NCOLS), .SW(SW), .RW(RW)
  ) u_store (
    .clk       (clk),
    .wr_en     (op.wr_row),
    .wr_slot   (slot_q),
    .wr_row    (addr[RW-1:0]),
    .wr_dots   (wdata[NCOLS-1:0]),
    .rd_slot_a (slot_q),
    .rd_row_a  (addr[RW-1:0]),
    .rd_dots_a (bus_dots),
    .rd_slot_b (scan_slot),
    .rd_row_b  (scan_row),
    .rd_dots_b (scan_dots)
  );

  always_comb begin
    rdata = '0;
    if (op.rd_ptr)      rdata = DW'(slot_q);
    else if (op.rd_row) rdata = DW'(bus_dots);
  end
endmodule

// File: rtl/glyph_ram_chk.sv
module glyph_ram_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 5,
  parameter int unsigned SW = 4,
  parameter int unsigned RW = 3,
  parameter int unsigned NCOLS = 5,
  parameter int unsigned NROWS = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             wr_n,
  input logic             rd_n,
  input logic             tgt_reg,
  input logic [AW-1:0]    addr,
  input logic [DW-1:0]    wdata,
  input logic [DW-1:0]    rdata,
  input logic [SW-1:0]    slot_q,
  input logic [SW-1:0]    scan_slot,
  input logic [RW-1:0]    scan_row,
  input logic [NCOLS-1:0] scan_dots
);
  logic is_rd;
  logic is_wr;
  assign is_rd = !cs_n && !rd_n && wr_n;
  assign is_wr = !cs_n && !wr_n && rd_n;

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !is_rd |-> (rdata == '0));

  p_row_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && !tgt_reg) |-> (rdata[DW-1:NCOLS] == '0));

  p_ptr_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && tgt_reg) |-> (rdata[DW-1:SW] == '0));

  p_ptr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && tgt_reg) |=> (slot_q == $past(wdata[SW-1:0])));

  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_wr && tgt_reg) |=> $stable(slot_q));

  p_row7_scan_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(scan_row) >= NROWS) |-> (scan_dots == '0));

  p_scan_sees_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && !tgt_reg && (32'(addr[RW-1:0]) < NROWS)) |=>
      ((scan_slot == $past(slot_q) && scan_row == $past(addr[RW-1:0]))
        |-> (scan_dots == $past(wdata[NCOLS-1:0]))));
endmodule

bind glyph_ram_top glyph_ram_chk #(
  .DW(DW), .AW(AW), .SW(SW), .RW(RW), .NCOLS(NCOLS), .NROWS(NROWS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cs_n      (cs_n),
  .wr_n      (wr_n),
  .rd_n      (rd_n),
  .tgt_reg   (tgt_reg),
  .addr      (addr),
  .wdata     (wdata),
  .rdata     (rdata),
  .slot_q    (slot_q),
  .scan_slot (scan_slot),
  .scan_row  (scan_row),
  .scan_dots (scan_dots)
);

// File: tb/tb_glyph_ram_top.sv
module tb_glyph_ram_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 3000;

  logic       clk;
  logic       rst_n;
  logic       cs_n, wr_n, rd_n, tgt_reg;
  logic [4:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [3:0] scan_slot;
  logic [2:0] scan_row;
  logic [4:0] scan_dots;

  int n_checks;
  int n_fail;

  logic [4:0] m_cells [16][7];
  logic [3:0] m_slot;

  glyph_ram_top dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .tgt_reg(tgt_reg), .addr(addr), .wdata(wdata), .rdata(rdata),
    .scan_slot(scan_slot), .scan_row(scan_row), .scan_dots(scan_dots)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [4:0] exp_dots(input logic [3:0] s, input logic [2:0] r);
    if (r == 3'b111) return 5'd0;
    return m_cells[s][r];
  endfunction

  function automatic logic [7:0] exp_row_read(input logic [2:0] r);
    return {3'b000, exp_dots(m_slot, r)};
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic idle();
    cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic bus_write(input logic sel, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    tgt_reg = sel; addr = a; wdata = d;
    cs_n = 1'b0; wr_n = 1'b0; rd_n = 1'b1;
    @(negedge clk);
    idle();
    if (sel) m_slot = d[3:0];
    else if (a[2:0] != 3'b111) m_cells[m_slot][a[2:0]] = d[4:0];
  endtask

  task automatic bus_read(input logic sel, input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    tgt_reg = sel; addr = a;
    cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1;
    #1 d = rdata;
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    n_checks = 0; n_fail = 0;
    void'($urandom(32'd20240611));
    idle(); tgt_reg = 1'b0; addr = '0; wdata = '0;
    scan_slot = '0; scan_row = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 check("R1 rdata in reset", rdata, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_slot = 4'd0;
    bus_read(1'b1, 5'd0, rd);
    check("R1 pointer after reset", rd, 8'h00);

    // R9 fill every slot; value depends on slot and row
    for (int s = 0; s < 16; s++) begin
      bus_write(1'b1, 5'd0, 8'(s));
      for (int r = 0; r < 7; r++)
        bus_write(1'b0, 5'(r), 8'((s * 7 + r) % 32));
    end
    for (int s = 0; s < 16; s++)
      for (int r = 0; r < 7; r++) begin
        @(negedge clk);
        scan_slot = 4'(s); scan_row = 3'(r);
        #1 check("R9 slot fill via scan", {3'b0, scan_dots}, 8'((s * 7 + r) % 32));
      end

    // R2 upper pointer bits ignored
    bus_write(1'b1, 5'd0, 8'hA5);
    bus_read(1'b1, 5'd0, rd);
    check("R2 pointer masks upper bits", rd, 8'h05);

    // R3 upper data / address bits ignored; R4 column order
    bus_write(1'b0, 5'b11_011, 8'hF0);
    bus_read(1'b0, 5'b00_011, rd);
    check("R3 row write masks upper", rd, 8'h10);
    check("R4 row read-back", rd, exp_row_read(3'd3));

    // R5 row 111
    bus_write(1'b0, 5'b00_111, 8'h1F);
    bus_read(1'b0, 5'b00_111, rd);
    check("R5 row 111 reads zero", rd, 8'h00);
    @(negedge clk); scan_slot = 4'd5; scan_row = 3'b111;
    #1 check("R5 scan row 111", {3'b0, scan_dots}, 8'h00);

    // R6 both strobes low
    @(negedge clk);
    tgt_reg = 1'b0; addr = 5'd2; wdata = 8'h0B;
    cs_n = 1'b0; wr_n = 1'b0; rd_n = 1'b0;
    #1 check("R6 rdata on both strobes", rdata, 8'h00);
    @(negedge clk); idle();
    bus_read(1'b0, 5'd2, rd);
    check("R6 row unchanged", rd, exp_row_read(3'd2));

    // R7 chip enable high
    @(negedge clk);
    tgt_reg = 1'b1; wdata = 8'h0C; cs_n = 1'b1; wr_n = 1'b0; rd_n = 1'b1;
    @(negedge clk); idle();
    bus_read(1'b1, 5'd0, rd);
    check("R7 pointer unchanged", rd, {4'h0, m_slot});

    // random mix
    for (int i = 0; i < N_RANDOM; i++) begin
      int unsigned kind;
      logic [7:0] d;
      logic [4:0] a;
      kind = $urandom_range(0, 7);
      d = 8'($urandom);
      a = 5'($urandom);
      case (kind)
        0: bus_write(1'b1, a, d);
        1, 2: bus_write(1'b0, a, d);
        3: begin
          bus_read(1'b1, a, rd);
          check("R2 pointer read", rd, {4'h0, m_slot});
        end
        4: begin
          bus_read(1'b0, a, rd);
          check("R4 row read", rd, exp_row_read(a[2:0]));
        end
        5: begin
          @(negedge clk);
          tgt_reg = d[7]; addr = a; wdata = d;
          cs_n = 1'b0; wr_n = 1'b0; rd_n = 1'b0;
          #1 check("R6 undefined cycle rdata", rdata, 8'h00);
          @(negedge clk); idle();
        end
        6: begin
          @(negedge clk);
          tgt_reg = d[7]; addr = a; wdata = d;
          cs_n = 1'b1; wr_n = d[0]; rd_n = ~d[0];
          #1 check("R10 deselected rdata", rdata, 8'h00);
          @(negedge clk); idle();
        end
        default: begin
          @(negedge clk);
          scan_slot = d[3:0]; scan_row = a[2:0];
          #1 check("R8 scan read", {3'b0, scan_dots}, {3'b0, exp_dots(d[3:0], a[2:0])});
        end
      endcase
    end

    // R1 mid-run reset clears pointer, keeps contents
    bus_write(1'b1, 5'd0, 8'h09);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_slot = 4'd0;
    bus_read(1'b1, 5'd0, rd);
    check("R1 pointer after second reset", rd, 8'h00);
    @(negedge clk); scan_slot = 4'd9; scan_row = 3'd4;
    #1 check("R8 contents survive reset", {3'b0, scan_dots}, {3'b0, exp_dots(4'd9, 3'd4)});

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule